// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits beside the transmit and receive FIFOs of a serial peripheral controller and turns their fill levels and strobes into status, interrupt and DMA request signals. It watches both FIFO levels, the push and pop strobes together with the FIFOs' full and empty conditions, and the serial engine's busy indication. It holds no FIFO storage and no serial logic.

Software reaches the unit through a small word-wide register port. Writes take effect on the clock edge, and reads are combinational on the address. The port carries the status word, raw, mask and masked interrupt words, a write-only clear word, two interrupt thresholds, a DMA enable word and two DMA trigger levels. The threshold and trigger-level registers hold only values below the FIFO depth. Because of this, software can find the depth by writing rising values and reading each one back. The unit drives a single combined interrupt line and one DMA request line for each direction.

Top module: `spi_fifo_monitor`

## Requirements
- R1: Address 0 reads the status word, bits above 4 reading 0. The bits are: bit 0 busy, bit 1 TX full, bit 2 TX empty, bit 3 RX empty, bit 4 RX full. Each bit follows its input in the same cycle.
- R2: Raw interrupt bit 0 (TX below threshold) is 1 whenever the TX level is less than or equal to the TX threshold register (address 5).
- R3: Raw interrupt bit 4 (RX above threshold) is 1 whenever the RX level is strictly greater than the RX threshold register (address 6).
- R4: Three raw interrupt bits are sticky, each set one cycle after its event and held until cleared. Bit 1 is set by a TX push while TX is full. Bit 2 is set by an RX pop while RX is empty. Bit 3 is set by an RX push while RX is full.
- R5: A write to address 4 clears sticky bits from the next cycle. Data bit 0 clears all three. Data bit 1 clears bit 2, data bit 2 clears bit 3, and data bit 3 clears bit 1. If an event occurs in the same cycle as its clear, the event wins.
- R6: Address 2 is the read/write 5-bit interrupt mask. Address 3 reads the raw word ANDed with the mask.
- R7: The interrupt output is high exactly when any masked interrupt bit is 1, in the same cycle.
- R8: The threshold and DMA level registers (addresses 5, 6, 8, 9) take a written value only when it is below DEPTH. Any other write leaves the old value in place.
- R9: Address 7 holds the DMA enables: bit 0 for RX and bit 1 for TX. The TX request is high while the TX DMA is enabled and the TX level is at most the TX DMA level (address 8). The RX request is high while the RX DMA is enabled and the RX level exceeds the RX DMA level (address 9).
- R10: After reset, the mask, both thresholds, the DMA enables, both DMA levels and all sticky bits are 0.
- R11: Address 1 reads the raw interrupt word. Address 4 and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| busy | input | 1 | Serial engine busy |
| tx_level | input | LVL_W | TX FIFO fill level |
| tx_push | input | 1 | TX FIFO push strobe |
| tx_full | input | 1 | TX FIFO full |
| tx_empty | input | 1 | TX FIFO empty |
| rx_level | input | LVL_W | RX FIFO fill level |
| rx_push | input | 1 | RX FIFO push strobe |
| rx_pop | input | 1 | RX FIFO pop strobe |
| rx_full | input | 1 | RX FIFO full |
| rx_empty | input | 1 | RX FIFO empty |
| irq | output | 1 | Combined interrupt |
| tx_dreq | output | 1 | TX DMA request |
| rx_dreq | output | 1 | RX DMA request |

## Verification
The embedded properties check the following on every cycle:
- Sticky flags are set after their event, held while no clear is pending, and dropped by a clear that has no coincident event.
- The limit registers never hold a value at or beyond DEPTH.
- With a zero mask the interrupt stays low.
- A DMA request stays low while its enable is off.

Other behaviour can only be shown by the bench's scenarios:
- The threshold comparisons at their exact boundaries.
- The bit routing of the clear word.
- Read-back of rejected writes.
- The priority of an event over a clear in the same cycle.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] A_STATUS = 4'd0;
   localparam logic [ADDR_W-1:0] A_RAW    = 4'd1;
   localparam logic [ADDR_W-1:0] A_MASK   = 4'd2;
   localparam logic [ADDR_W-1:0] A_MASKED = 4'd3;
   localparam logic [ADDR_W-1:0] A_CLEAR  = 4'd4;
   localparam logic [ADDR_W-1:0] A_TXTHR  = 4'd5;
   localparam logic [ADDR_W-1:0] A_RXTHR  = 4'd6;
   localparam logic [ADDR_W-1:0] A_DMAEN  = 4'd7;
   localparam logic [ADDR_W-1:0] A_TXDLV  = 4'd8;
   localparam logic [ADDR_W-1:0] A_RXDLV  = 4'd9;

   localparam int NUM_IRQ    = 5;
   localparam int NUM_STICKY = 3;
   localparam int CLR_W      = 4;

   // sticky flag k sits at raw bit k+1; this returns the clear-word bit for it
   function automatic int clr_bit_of(input int k);
      return (k == 0) ? 3 : k;
   endfunction
endpackage

// File: rtl/sfm_cfg_regs.sv
module sfm_cfg_regs
   import sfm_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int THR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wen,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [NUM_IRQ-1:0] mask,
   output logic [1:0]        dma_en,
   output logic [THR_W-1:0]  tx_thr,
   output logic [THR_W-1:0]  rx_thr,
   output logic [THR_W-1:0]  tx_dlvl,
   output logic [THR_W-1:0]  rx_dlvl,
   output logic [CLR_W-1:0]  clr_vec
);
   localparam int NUM_LIM = 4;
   localparam logic [ADDR_W-1:0] LIM_ADDR [NUM_LIM] = '{A_TXTHR, A_RXTHR, A_TXDLV, A_RXDLV};

   logic [THR_W-1:0] lim_q [NUM_LIM];
   logic             in_range;

   assign in_range = 32'(wdata) < DEPTH;

   for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lim_q[g] <= '0;
         else if (wen && addr == LIM_ADDR[g] && in_range)
            lim_q[g] <= wdata[THR_W-1:0];
      end
      AST_LIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         32'(lim_q[g]) < DEPTH);  // R8
      AST_LIM_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
         (wen && addr == LIM_ADDR[g] && !in_range) |=> $stable(lim_q[g]));  // R8
   end

   assign tx_thr  = lim_q[0];
   assign rx_thr  = lim_q[1];
   assign tx_dlvl = lim_q[2];
   assign rx_dlvl = lim_q[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask   <= '0;
         dma_en <= '0;
      end else if (wen) begin
         if (addr == A_MASK)  mask   <= wdata[NUM_IRQ-1:0];
         if (addr == A_DMAEN) dma_en <= wdata[1:0];
      end
   end

   assign clr_vec = (wen && addr == A_CLEAR) ? wdata[CLR_W-1:0] : '0;
endmodule

// File: rtl/sfm_err_flags.sv
module sfm_err_flags
   import sfm_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_STICKY-1:0] set_vec,
   input  logic [CLR_W-1:0]      clr_vec,
   output logic [NUM_STICKY-1:0] flags
);
   for (genvar k = 0; k < NUM_STICKY; k++) begin : g_flag
      logic clr_k;
      assign clr_k = clr_vec[0] | clr_vec[clr_bit_of(k)];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flags[k] <= 1'b0;
         else if (set_vec[k]) flags[k] <= 1'b1;
         else if (clr_k)      flags[k] <= 1'b0;
      end

      AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[k] |=> flags[k]);  // R4
      AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[k] && !clr_k) |=> flags[k]);  // R4
      AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_k && !set_vec[k]) |=> !flags[k]);  // R5
   end
endmodule

// File: rtl/sfm_level_eval.sv
module sfm_level_eval #(
   parameter int DEPTH = 16,
   localparam int LVL_W = $clog2(DEPTH + 1),
   localparam int THR_W = $clog2(DEPTH)
) (
   input  logic [LVL_W-1:0] tx_level,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [THR_W-1:0] tx_thr,
   input  logic [THR_W-1:0] rx_thr,
   input  logic [THR_W-1:0] tx_dlvl,
   input  logic [THR_W-1:0] rx_dlvl,
   input  logic [1:0]       dma_en,
   output logic             tx_low,
   output logic             rx_high,
   output logic             tx_dreq,
   output logic             rx_dreq
);
   assign tx_low  = tx_level <= LVL_W'(tx_thr);
   assign rx_high = rx_level >  LVL_W'(rx_thr);
   assign tx_dreq = dma_en[1] && (tx_level <= LVL_W'(tx_dlvl));
   assign rx_dreq = dma_en[0] && (rx_level >  LVL_W'(rx_dlvl));
endmodule

// File: rtl/spi_fifo_monitor.sv
module spi_fifo_monitor
   import sfm_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0,
   localparam int LVL_W  = $clog2(DEPTH + 1),
   localparam int THR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wen,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              busy,
   input  logic [LVL_W-1:0]  tx_level,
   input  logic              tx_push,
   input  logic              tx_full,
   input  logic              tx_empty,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic              rx_push,
   input  logic              rx_pop,
   input  logic              rx_full,
   input  logic              rx_empty,
   output logic              irq,
   output logic              tx_dreq,
   output logic              rx_dreq
);
   initial begin
      if (DEPTH < 2)
         $error("DEPTH must be at least 2");
      if (DATA_W < NUM_IRQ || DATA_W < THR_W)
         $error("DATA_W too narrow for the register fields");
   end

   logic [NUM_IRQ-1:0]    mask, raw, masked, status;
   logic [1:0]            dma_en;
   logic [THR_W-1:0]      tx_thr, rx_thr, tx_dlvl, rx_dlvl;
   logic [CLR_W-1:0]      clr_vec;
   logic [NUM_STICKY-1:0] set_vec, flags;
   logic                  tx_low, rx_high;

   sfm_cfg_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
      .mask(mask), .dma_en(dma_en), .tx_thr(tx_thr), .rx_thr(rx_thr),
      .tx_dlvl(tx_dlvl), .rx_dlvl(rx_dlvl), .clr_vec(clr_vec)
   );

   assign set_vec = {rx_push & rx_full, rx_pop & rx_empty, tx_push & tx_full};

   sfm_err_flags u_err (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
   );

   sfm_level_eval #(.DEPTH(DEPTH)) u_lvl (
      .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr), .rx_thr(rx_thr),
      .tx_dlvl(tx_dlvl), .rx_dlvl(rx_dlvl), .dma_en(dma_en),
      .tx_low(tx_low), .rx_high(rx_high), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
   );

   assign raw    = {rx_high, flags, tx_low};
   assign masked = raw & mask;
   assign status = {rx_full, rx_empty, tx_empty, tx_full, busy};

   always_comb begin
      unique case (reg_addr)
         A_STATUS: reg_rdata = DATA_W'(status);
         A_RAW:    reg_rdata = DATA_W'(raw);
         A_MASK:   reg_rdata = DATA_W'(mask);
         A_MASKED: reg_rdata = DATA_W'(masked);
         A_TXTHR:  reg_rdata = DATA_W'(tx_thr);
         A_RXTHR:  reg_rdata = DATA_W'(rx_thr);
         A_DMAEN:  reg_rdata = DATA_W'(dma_en);
         A_TXDLV:  reg_rdata = DATA_W'(tx_dlvl);
         A_RXDLV:  reg_rdata = DATA_W'(rx_dlvl);
         default:  reg_rdata = '0;
      endcase
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |masked;
      end
   end else begin : g_irq_comb
      assign irq = |masked;
      AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (mask == '0) |-> !irq);  // R7
   end

   AST_TXDREQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en[1] |-> !tx_dreq);  // R9
   AST_RXDREQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en[0] |-> !rx_dreq);  // R9
endmodule

// File: tb/spi_fifo_monitor_test.sv
module spi_fifo_monitor_test;
   localparam int DEPTH  = 16;
   localparam int DATA_W = 8;
   localparam int LVL_W  = $clog2(DEPTH + 1);

   logic clk = 0, rst_n = 0;
   logic [3:0] reg_addr = 0;
   logic reg_wen = 0;
   logic [DATA_W-1:0] reg_wdata = 0, reg_rdata;
   logic busy = 0, tx_push = 0, tx_full = 0, tx_empty = 0;
   logic rx_push = 0, rx_pop = 0, rx_full = 0, rx_empty = 0;
   logic [LVL_W-1:0] tx_level = 0, rx_level = 0;
   logic irq, tx_dreq, rx_dreq;

   int total = 0, bad = 0;
   // reference model state
   int m_mask = 0, m_dma = 0, m_txthr = 0, m_rxthr = 0, m_txdl = 0, m_rxdl = 0;
   int m_txovf = 0, m_rxund = 0, m_rxovf = 0;

   always #10 clk = ~clk;

   spi_fifo_monitor #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
      .tx_level(tx_level), .tx_push(tx_push), .tx_full(tx_full), .tx_empty(tx_empty),
      .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop),
      .rx_full(rx_full), .rx_empty(rx_empty),
      .irq(irq), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h (addr=%0d)", req, act, exp, reg_addr);
      end
   endtask

   function automatic int exp_raw();
      return ((int'(rx_level) > m_rxthr) << 4) | (m_rxovf << 3) | (m_rxund << 2) |
             (m_txovf << 1) | int'(int'(tx_level) <= m_txthr);
   endfunction

   function automatic int exp_rd();
      case (reg_addr)
         0: return {rx_full, rx_empty, tx_empty, tx_full, busy};
         1: return exp_raw();
         2: return m_mask;
         3: return exp_raw() & m_mask;
         5: return m_txthr;
         6: return m_rxthr;
         7: return m_dma;
         8: return m_txdl;
         9: return m_rxdl;
         default: return 0;
      endcase
   endfunction

   function automatic string req_of(input int a);
      case (a)
         0: return "R1 status";
         1: return "R2 R3 R4 R11 raw";
         2, 3: return "R6 mask";
         5, 6, 8, 9: return "R8 limit";
         7: return "R9 dma enable";
         default: return "R5 R11 zero read";
      endcase
   endfunction

   // compare outputs, then advance model across one clock edge
   task automatic step();
      int wd;
      #1;
      chk(req_of(reg_addr), reg_rdata, exp_rd());
      chk("R7 irq", irq, int'((exp_raw() & m_mask) != 0));
      chk("R9 tx_dreq", tx_dreq, int'(m_dma[1] && int'(tx_level) <= m_txdl));
      chk("R9 rx_dreq", rx_dreq, int'(m_dma[0] && int'(rx_level) > m_rxdl));
      @(posedge clk);
      wd = reg_wdata;
      if (reg_wen) begin
         case (reg_addr)
            2: m_mask = wd & 31;
            4: begin
               if (wd & 1) begin m_txovf = 0; m_rxund = 0; m_rxovf = 0; end
               if (wd & 2) m_rxund = 0;
               if (wd & 4) m_rxovf = 0;
               if (wd & 8) m_txovf = 0;
            end
            5: if (wd < DEPTH) m_txthr = wd;
            6: if (wd < DEPTH) m_rxthr = wd;
            7: m_dma = wd & 3;
            8: if (wd < DEPTH) m_txdl = wd;
            9: if (wd < DEPTH) m_rxdl = wd;
            default: ;
         endcase
      end
      if (tx_push && tx_full)  m_txovf = 1;
      if (rx_pop && rx_empty)  m_rxund = 1;
      if (rx_push && rx_full)  m_rxovf = 1;
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      reg_wen = 1; reg_addr = 4'(a); reg_wdata = DATA_W'(d);
      step();
      reg_wen = 0;
   endtask

   task automatic rd_chk(input string req, input int a, input int exp);
      reg_addr = 4'(a);
      #1 chk(req, reg_rdata, exp);
      step();
   endtask

   initial begin
      #(20ns * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10 reset state
      for (int a = 2; a < 10; a++) if (a != 3 && a != 4) rd_chk("R10 reset value", a, 0);
      rd_chk("R10 R4 sticky clear after reset", 1, 1);  // tx level 0 <= threshold 0
      // R1 status routing
      busy = 1; rx_full = 1;
      rd_chk("R1 status bits", 0, 5'b10001);
      busy = 0; rx_full = 0; tx_empty = 1; rx_empty = 1;
      rd_chk("R1 status bits", 0, 5'b01100);
      // R8 threshold depth discovery
      wr(5, DEPTH - 1); wr(5, DEPTH);
      rd_chk("R8 reject at DEPTH", 5, DEPTH - 1);
      wr(6, 3); wr(6, 200);
      rd_chk("R8 reject high", 6, 3);
      // R2 boundary
      tx_level = LVL_W'(DEPTH - 1);
      rd_chk("R2 equal sets", 1, 1);
      wr(5, 4); tx_level = 5;
      rd_chk("R2 above clears", 1, 0);
      // R3 boundary
      rx_level = 3;
      rd_chk("R3 equal not set", 1, 0);
      rx_level = 4;
      rd_chk("R3 above sets", 1, 16);
      // R4 sticky set and hold, R5 per-bit clear
      rx_level = 0; tx_push = 1; tx_full = 1; step();
      tx_push = 0; tx_full = 0;
      rd_chk("R4 tx overflow sticky", 1, 2);
      rx_pop = 1; rx_empty = 1; step(); rx_pop = 0;
      rx_push = 1; rx_full = 1; step(); rx_push = 0; rx_full = 0;
      rd_chk("R4 all sticky", 1, 14);
      wr(4, 4'b0010);
      rd_chk("R5 clear rx underflow", 1, 10);
      wr(4, 4'b1000);
      rd_chk("R5 clear tx overflow", 1, 8);
      // R5 event beats clear
      rx_pop = 1; wr(4, 1); rx_pop = 0;
      rd_chk("R5 set wins over clear-all", 1, 4);
      wr(4, 1);
      rd_chk("R5 clear all", 1, 0);
      // R6/R7 mask
      wr(2, 5'b00100); rx_pop = 1; step(); rx_pop = 0;
      rd_chk("R6 masked", 3, 4);
      #1 chk("R7 irq high", irq, 1);
      wr(2, 5'b00010);
      #1 chk("R7 irq low", irq, 0);
      // R9 dma
      wr(7, 2); wr(8, 6); tx_level = 6;
      #1 chk("R9 tx dreq at level", tx_dreq, 1);
      step();
      wr(7, 1); wr(9, 2); rx_level = 2;
      #1 chk("R9 rx dreq equal low", rx_dreq, 0);
      rx_level = 3;
      #1 chk("R9 rx dreq above", rx_dreq, 1);
      step();
      // random phase compared against the model every clock
      for (int i = 0; i < 3000; i++) begin
         reg_addr  = 4'($urandom_range(0, 11));
         reg_wen   = ($urandom_range(0, 3) == 0);
         reg_wdata = DATA_W'($urandom_range(0, 20));
         busy = 1'($urandom); tx_push = 1'($urandom); tx_full = 1'($urandom);
         tx_empty = 1'($urandom); rx_push = 1'($urandom); rx_pop = 1'($urandom);
         rx_full = 1'($urandom); rx_empty = 1'($urandom);
         tx_level = LVL_W'($urandom_range(0, DEPTH));
         rx_level = LVL_W'($urandom_range(0, DEPTH));
         step();
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule